// File: doc/BRIEF.md
# Soft-Start and Fault-Latch Supervisor

This block is the digital sequencer for a regulator with three outputs: one switched core rail and two auxiliary linear rails. It waits until the bias, 5 V and 3.3 V supplies all report ready. It then drives a soft-start ramp value, modelled as a counter, and enables every output while that ramp is charging or complete. The ramp jumps at once to a floor value and then climbs one step per prescaler tick until it reaches a ceiling, where a completion flag rises.

Over-voltage on the core rail latches a fault at once. An over-current event, or an auxiliary under-voltage seen after the ramp has completed, turns the outputs off and drains the ramp at its charging rate. The event is also counted, and the ramp then restarts. The event that brings the count to the limit sets the fault latch instead of starting another retry. Only a drop of the bias supply clears the latch and the count. A shutdown request, an inhibit flag or a drop of the 5 V or 3.3 V supply turns everything off. The block starts a fresh soft-start when that condition goes away.

Top module: `softstart_supervisor`

## Requirements
- R1: After reset, and while any of the three supply-ready inputs is low, out_en is 0, ramp_val is 0 and fault_lat is 0.
- R2: The first cycle after all supplies are ready with no shutdown, inhibit or fault, out_en is 1 and ramp_val equals RAMP_FLOOR.
- R3: While charging, ramp_val rises by one every TICK_DIV cycles. ramp_done goes to 1 exactly (RAMP_CEIL-RAMP_FLOOR)*TICK_DIV cycles after the floor load, with ramp_val holding RAMP_CEIL.
- R4: ovp_flag high while bias_ok is high sets fault_lat and clears out_en and ramp_val on the next cycle, and the latch stays set after ovp_flag falls.
- R5: An over-current event clears out_en on the next cycle. ramp_val then falls by one every TICK_DIV cycles to 0, and the next cycle restarts at RAMP_FLOOR with out_en 1.
- R6: The event that brings the count to OC_LIMIT (3 by default) sets fault_lat with outputs off and no further retry. The count survives shutdown and inhibit restarts.
- R7: Any aux_uv bit is ignored while the ramp is charging and counts as an over-current event once ramp_done is 1.
- R8: A sustained ocp_flag counts once per restart. out_en is high for one cycle per attempt, and the limit is reached after exactly OC_LIMIT attempts.
- R9: bias_ok low clears fault_lat and the event count. When bias_ok returns, a fresh soft-start begins.
- R10: shut_req or inhibit clears out_en and ramp_val on the next cycle. When released, the ramp restarts at RAMP_FLOOR.
- R11: low_ok falling during operation clears out_en and ramp_val on the next cycle. Its return starts a new soft-start.
- R12: While fault_lat is set, shut_req, inhibit, mid_ok and low_ok have no effect on fault_lat or out_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply above its threshold |
| mid_ok | input | 1 | 5 V supply ready |
| low_ok | input | 1 | 3.3 V supply ready |
| shut_req | input | 1 | External shutdown request |
| inhibit | input | 1 | Output-voltage code selects inhibit |
| ovp_flag | input | 1 | Core rail over-voltage |
| ocp_flag | input | 1 | Core rail over-current this cycle |
| aux_uv | input | AUX_N | Under-voltage flags of the auxiliary rails |
| ramp_val | output | RAMP_W | Soft-start ramp level |
| out_en | output | 1 | Enable for all regulated outputs |
| ramp_done | output | 1 | Ramp has reached its ceiling |
| fault_lat | output | 1 | Latched fault |

## Verification
The main sequence runs under several stimulus shapes, and each one separates a different path. A clean start tells the floor jump and step rate apart from an off-by-one in the prescaler. Single-cycle over-current pulses from the completed state measure the drain slope and the restart point. A flag held high through every restart shows whether an event is counted once per attempt or once per cycle. An auxiliary flag raised before charging starts shows whether it is masked until completion. Shutdown, inhibit and supply drops placed between events show that the retry count survives everything except a bias cycle.

// File: rtl/ssv_pkg.sv
package ssv_pkg;

  typedef enum logic [2:0] {
    SS_IDLE   = 3'd0,
    SS_CHARGE = 3'd1,
    SS_RUN    = 3'd2,
    SS_DRAIN  = 3'd3,
    SS_LOCK   = 3'd4
  } ss_state_e;

  // Bits needed to hold values 0..maxval.
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

  // Cycles spent charging from the floor load to completion.
  function automatic int unsigned charge_span(input int unsigned lo,
                                              input int unsigned hi,
                                              input int unsigned div);
    return (hi - lo) * div;
  endfunction

endpackage

// File: rtl/ssv_tick.sv
module ssv_tick
  import ssv_pkg::*;
#(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = cnt_width(DIV - 1);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run || restart || tick) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ssv_ramp.sv
module ssv_ramp
  import ssv_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned FLOOR = 64,
  parameter int unsigned CEIL  = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] level,
  output logic         near_top,
  output logic         near_bottom
);
  localparam logic [W-1:0] FLOOR_V = W'(FLOOR);
  localparam logic [W-1:0] CEIL_V  = W'(CEIL);
  localparam logic [W-1:0] TOP_M1  = W'(CEIL - 1);

  logic [W-1:0] level_q;

  assign level       = level_q;
  assign near_top    = (level_q >= TOP_M1);
  assign near_bottom = (level_q <= W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          level_q <= '0;
    else if (clear)                      level_q <= '0;
    else if (load)                       level_q <= FLOOR_V;
    else if (up && level_q != CEIL_V)    level_q <= level_q + 1'b1;
    else if (down && level_q != '0)      level_q <= level_q - 1'b1;
  end
endmodule

// File: rtl/ssv_oc_tally.sv
module ssv_oc_tally
  import ssv_pkg::*;
#(
  parameter int unsigned LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic is_last
);
  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] count_q;

  assign is_last = (count_q >= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count_q <= '0;
    else if (clr)                  count_q <= '0;
    else if (bump && count_q != TOP) count_q <= count_q + 1'b1;
  end
endmodule

// File: rtl/softstart_supervisor.sv
module softstart_supervisor
  import ssv_pkg::*;
#(
  parameter int unsigned RAMP_W     = 8,
  parameter int unsigned RAMP_FLOOR = 64,
  parameter int unsigned RAMP_CEIL  = 255,
  parameter int unsigned TICK_DIV   = 16,
  parameter int unsigned OC_LIMIT   = 3,
  parameter int unsigned AUX_N      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bias_ok,
  input  logic              mid_ok,
  input  logic              low_ok,
  input  logic              shut_req,
  input  logic              inhibit,
  input  logic              ovp_flag,
  input  logic              ocp_flag,
  input  logic [AUX_N-1:0]  aux_uv,
  output logic [RAMP_W-1:0] ramp_val,
  output logic              out_en,
  output logic              ramp_done,
  output logic              fault_lat
);
  ss_state_e state_q, nstate;

  // Named internal events, also observed by the checker.
  logic stop_req, oc_event, aux_low;
  logic charge_on, run_on, drain_on, lock_set;
  logic tick, restart;
  logic r_clear, r_load, r_up, r_down;
  logic near_top, near_bottom;
  logic oc_clr, oc_bump, oc_last;
  logic fault_q;

  assign aux_low   = |aux_uv;
  assign stop_req  = shut_req | inhibit | ~mid_ok | ~low_ok;
  assign charge_on = (state_q == SS_CHARGE);
  assign run_on    = (state_q == SS_RUN);
  assign drain_on  = (state_q == SS_DRAIN);
  assign oc_event  = (charge_on && ocp_flag) || (run_on && (ocp_flag || aux_low));
  assign restart   = (nstate != state_q);
  assign lock_set  = (nstate == SS_LOCK) && (state_q != SS_LOCK);

  ssv_tick #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (charge_on | drain_on),
    .restart (restart),
    .tick    (tick)
  );

  ssv_ramp #(.W(RAMP_W), .FLOOR(RAMP_FLOOR), .CEIL(RAMP_CEIL)) u_ramp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (r_clear),
    .load        (r_load),
    .up          (r_up),
    .down        (r_down),
    .level       (ramp_val),
    .near_top    (near_top),
    .near_bottom (near_bottom)
  );

  ssv_oc_tally #(.LIMIT(OC_LIMIT)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (oc_clr),
    .bump    (oc_bump),
    .is_last (oc_last)
  );

  always_comb begin
    nstate  = state_q;
    r_clear = 1'b0;
    r_load  = 1'b0;
    r_up    = 1'b0;
    r_down  = 1'b0;
    oc_clr  = 1'b0;
    oc_bump = 1'b0;
    if (!bias_ok) begin
      nstate  = SS_IDLE;
      r_clear = 1'b1;
      oc_clr  = 1'b1;
    end else if (ovp_flag) begin
      nstate  = SS_LOCK;
      r_clear = 1'b1;
    end else begin
      case (state_q)
        SS_IDLE: begin
          if (!stop_req) begin
            nstate = SS_CHARGE;
            r_load = 1'b1;
          end
        end
        SS_CHARGE, SS_RUN, SS_DRAIN: begin
          if (stop_req) begin
            nstate  = SS_IDLE;
            r_clear = 1'b1;
          end else if (oc_event) begin
            oc_bump = 1'b1;
            if (oc_last) begin
              nstate  = SS_LOCK;
              r_clear = 1'b1;
            end else begin
              nstate = SS_DRAIN;
            end
          end else if (charge_on && tick) begin
            r_up = 1'b1;
            if (near_top) nstate = SS_RUN;
          end else if (drain_on && tick) begin
            r_down = 1'b1;
            if (near_bottom) nstate = SS_IDLE;
          end
        end
        SS_LOCK: r_clear = 1'b1;
        default: nstate = SS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SS_IDLE;
    else        state_q <= nstate;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fault_q <= 1'b0;
    else if (!bias_ok) fault_q <= 1'b0;
    else if (lock_set) fault_q <= 1'b1;
  end

  assign out_en    = charge_on | run_on;
  assign ramp_done = run_on;
  assign fault_lat = fault_q;
endmodule

// File: rtl/ssv_checker.sv
module ssv_checker
  import ssv_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned FLOOR = 64,
  parameter int unsigned CEIL  = 255,
  parameter int unsigned DIV   = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bias_ok,
  input logic         ovp_flag,
  input logic         ocp_flag,
  input logic         stop_req,
  input logic         oc_event,
  input logic         charge_on,
  input logic         run_on,
  input logic         drain_on,
  input logic         out_en,
  input logic         ramp_done,
  input logic         fault_lat,
  input logic [W-1:0] ramp_val
);
  localparam int unsigned SPAN = charge_span(FLOOR, CEIL, DIV);

  int unsigned span_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         span_q <= 0;
    else if (charge_on) span_q <= span_q + 1;
    else                span_q <= 0;
  end

  p_states_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({charge_on, run_on, drain_on}));

  p_floor_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> ramp_val == W'(FLOOR));

  p_charge_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    charge_on |=> (ramp_val >= $past(ramp_val)) || (ramp_val == '0));

  p_done_at_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |-> ramp_val == W'(CEIL));

  p_charge_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_on) |-> span_q == SPAN);

  p_ovp_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bias_ok && ovp_flag |=> fault_lat && !out_en);

  p_event_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oc_event |=> !out_en);

  p_drain_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_on |=> ramp_val <= $past(ramp_val));

  p_lock_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_lat |-> !out_en && ramp_val == '0);

  p_aux_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    charge_on && bias_ok && !ovp_flag && !ocp_flag && !stop_req |=> out_en);

  p_fault_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fault_lat && bias_ok |=> fault_lat);
endmodule

bind softstart_supervisor ssv_checker #(
  .W(RAMP_W), .FLOOR(RAMP_FLOOR), .CEIL(RAMP_CEIL), .DIV(TICK_DIV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bias_ok   (bias_ok),
  .ovp_flag  (ovp_flag),
  .ocp_flag  (ocp_flag),
  .stop_req  (stop_req),
  .oc_event  (oc_event),
  .charge_on (charge_on),
  .run_on    (run_on),
  .drain_on  (drain_on),
  .out_en    (out_en),
  .ramp_done (ramp_done),
  .fault_lat (fault_lat),
  .ramp_val  (ramp_val)
);

// File: tb/softstart_supervisor_test.sv
module softstart_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int FL  = 10;
  localparam int CE  = 40;
  localparam int DV  = 3;
  localparam int LIM = 3;
  localparam int NA  = 2;
  localparam int SPAN      = (CE - FL) * DV;
  localparam int DRAIN_TOP = CE * DV;
  localparam int S_EN = 0, S_DONE = 1, S_FAULT = 2, S_RAMP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bias_ok = 1'b0, mid_ok = 1'b0, low_ok = 1'b0;
  logic shut_req = 1'b0, inhibit = 1'b0, ovp_flag = 1'b0, ocp_flag = 1'b0;
  logic [NA-1:0] aux_uv = '0;
  logic [W-1:0] ramp_val;
  logic out_en, ramp_done, fault_lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  softstart_supervisor #(
    .RAMP_W(W), .RAMP_FLOOR(FL), .RAMP_CEIL(CE),
    .TICK_DIV(DV), .OC_LIMIT(LIM), .AUX_N(NA)
  ) uut (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .mid_ok(mid_ok),
    .low_ok(low_ok), .shut_req(shut_req), .inhibit(inhibit),
    .ovp_flag(ovp_flag), .ocp_flag(ocp_flag), .aux_uv(aux_uv),
    .ramp_val(ramp_val), .out_en(out_en), .ramp_done(ramp_done),
    .fault_lat(fault_lat)
  );

  typedef struct {
    int    at;
    int    sig;
    int    val;
    string req;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pick(input int sig);
    case (sig)
      S_EN:    return int'(out_en);
      S_DONE:  return int'(ramp_done);
      S_FAULT: return int'(fault_lat);
      default: return int'(ramp_val);
    endcase
  endfunction

  // Monitor: pops every expectation due in this cycle and compares it.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        n_run++;
        if (pick(q[i].sig) != q[i].val) begin
          n_fail++;
          $display("FAIL %s sig=%0d actual=%0d expected=%0d at cycle %0d",
                   q[i].req, q[i].sig, pick(q[i].sig), q[i].val, cyc);
        end
        q.delete(i);
      end
    end
  end

  task automatic push(input int k, input int sig, input int val, input string req);
    exp_t e;
    e.at = cyc + k; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    n_run++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Restart from idle: floor load next cycle, completion SPAN cycles later.
  task automatic restart_full(input string req);
    push(1, S_EN, 1, req);
    push(1, S_RAMP, FL, req);
    step(1);
    step(SPAN - 1);
    push(1, S_DONE, 1, req);
    push(1, S_RAMP, CE, req);
    step(1);
  endtask

  // One non-final over-current event from the completed state.
  task automatic oc_cycle(input string req);
    ocp_flag = 1'b1;
    push(1, S_EN, 0, req);
    step(1);
    ocp_flag = 1'b0;
    step(DRAIN_TOP);
    restart_full(req);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    push(1, S_EN, 0, "R1 reset");
    push(1, S_RAMP, 0, "R1 reset");
    push(1, S_FAULT, 0, "R1 reset");
    step(1);

    bias_ok = 1'b1; mid_ok = 1'b1;
    step(4); push(1, S_EN, 0, "R1 3.3V missing"); step(1);
    mid_ok = 1'b0; low_ok = 1'b1;
    step(4); push(1, S_EN, 0, "R1 5V missing"); step(1);
    bias_ok = 1'b0; mid_ok = 1'b1;
    step(4); push(1, S_EN, 0, "R1 bias missing"); step(1);

    // R2/R3: clean start
    bias_ok = 1'b1;
    push(1, S_EN, 1, "R2 enable");
    push(1, S_RAMP, FL, "R2 floor");
    push(DV, S_RAMP, FL, "R3 before first tick");
    push(DV + 1, S_RAMP, FL + 1, "R3 first step");
    push(SPAN, S_DONE, 0, "R3 not yet done");
    push(SPAN + 1, S_DONE, 1, "R3 done");
    push(SPAN + 1, S_RAMP, CE, "R3 ceiling");
    step(SPAN + 1);
    step(3); push(1, S_RAMP, CE, "R3 holds ceiling"); step(1);

    // R5: single over-current pulse, drain and restart
    ocp_flag = 1'b1;
    push(1, S_EN, 0, "R5 off");
    push(1, S_RAMP, CE, "R5 drain start");
    push(DV, S_RAMP, CE, "R5 drain before tick");
    push(DV + 1, S_RAMP, CE - 1, "R5 drain step");
    push(DRAIN_TOP + 1, S_RAMP, 0, "R5 drained");
    push(DRAIN_TOP + 1, S_EN, 0, "R5 still off");
    step(1);
    ocp_flag = 1'b0;
    step(DRAIN_TOP);
    restart_full("R5 restart");

    // R10: shutdown and inhibit
    shut_req = 1'b1;
    push(1, S_EN, 0, "R10 shutdown");
    push(1, S_RAMP, 0, "R10 shutdown");
    step(5); push(1, S_EN, 0, "R10 held"); step(1);
    shut_req = 1'b0;
    restart_full("R10 after shutdown");
    inhibit = 1'b1;
    push(1, S_EN, 0, "R10 inhibit");
    push(1, S_RAMP, 0, "R10 inhibit");
    step(3);
    inhibit = 1'b0;
    restart_full("R10 after inhibit");

    // R6: count survives restarts; third event latches
    oc_cycle("R6 second event");
    ocp_flag = 1'b1;
    push(1, S_FAULT, 1, "R6 latch");
    push(1, S_EN, 0, "R6 latch");
    push(1, S_RAMP, 0, "R6 latch");
    step(1);
    ocp_flag = 1'b0;
    step(DRAIN_TOP + 5);
    push(1, S_FAULT, 1, "R6 no retry");
    push(1, S_EN, 0, "R6 no retry");
    step(1);

    // R12: other inputs ignored while latched
    shut_req = 1'b1; inhibit = 1'b1; low_ok = 1'b0; mid_ok = 1'b0;
    step(4);
    push(1, S_FAULT, 1, "R12 inputs toggled");
    push(1, S_EN, 0, "R12 inputs toggled");
    step(1);
    shut_req = 1'b0; inhibit = 1'b0; low_ok = 1'b1; mid_ok = 1'b1;
    step(3);
    push(1, S_FAULT, 1, "R12 inputs restored");
    push(1, S_EN, 0, "R12 inputs restored");
    step(1);

    // R9: bias cycle clears latch and count
    bias_ok = 1'b0;
    push(1, S_FAULT, 0, "R9 cleared");
    push(1, S_EN, 0, "R9 cleared");
    step(2);
    bias_ok = 1'b1;
    restart_full("R9 fresh start");
    oc_cycle("R9 count cleared");
    oc_cycle("R9 count cleared");
    push(1, S_FAULT, 0, "R9 no latch after two");
    step(1);

    // R11: 3.3 V drop and recovery
    low_ok = 1'b0;
    push(1, S_EN, 0, "R11 drop");
    push(1, S_RAMP, 0, "R11 drop");
    step(3);
    low_ok = 1'b1;
    restart_full("R11 recovery");

    // R7: aux under-voltage masked until done
    bias_ok = 1'b0;
    step(2);
    bias_ok = 1'b1;
    aux_uv = 2'b10;
    push(SPAN, S_EN, 1, "R7 ignored while charging");
    restart_full("R7 completes despite aux");
    push(1, S_EN, 0, "R7 counted after done");
    step(1);
    aux_uv = '0;
    step(DRAIN_TOP);
    restart_full("R7 retry");

    // R4: over-voltage latches immediately
    bias_ok = 1'b0;
    step(2);
    bias_ok = 1'b1;
    step(5);
    ovp_flag = 1'b1;
    push(1, S_FAULT, 1, "R4 latch");
    push(1, S_EN, 0, "R4 latch");
    push(1, S_RAMP, 0, "R4 latch");
    step(1);
    ovp_flag = 1'b0;
    step(5);
    push(1, S_FAULT, 1, "R4 stays latched");
    step(1);

    // R8: sustained over-current counts once per attempt
    bias_ok = 1'b0;
    step(2);
    ocp_flag = 1'b1;
    bias_ok = 1'b1;
    begin
      int rises = 0;
      int highs = 0;
      logic prev = 1'b0;
      for (int i = 0; i < 3 * (FL * DV + 2) + 10; i++) begin
        step(1);
        if (out_en) highs++;
        if (out_en && !prev) rises++;
        prev = out_en;
      end
      chk("R8 attempts", rises, LIM);
      chk("R8 one cycle each", highs, LIM);
      chk("R8 latched", int'(fault_lat), 1);
    end
    ocp_flag = 1'b0;

    step(3);
    chk("R1 all expectations consumed", q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule